// File: doc/BRIEF.md
# Addressed Sensor Command Sequencer

This block runs one fixed, two-phase transaction against a single temperature sensor on a shared single-wire bus. It never touches the pad timing itself. It hands one slot at a time to a separate bit-slot engine: a reset-and-presence slot, a write slot or a read slot. It then waits for that engine to report completion. A pulse on `start` latches the 64-bit device identifier and the sequence begins.

In the first phase the block resets the bus and addresses the device (select code 55h, then the identifier). It then issues the conversion command 44h and raises `spu_en` for a programmable number of clock cycles. During that time no slot is issued, so the pad drives the line hard high while the sensor converts. In the second phase the block resets the bus and addresses the same device again. It then sends the scratchpad read command BEh and collects 72 bits. It checks those bits with a serial CRC-8.

At the end the block pulses `done` and presents the scratchpad together with two error flags. A missing presence response ends the transaction early.

Top module: `sensor_seq`

## Requirements
- R1: After a synchronous active-low reset, and whenever the block is idle, `req_go`, `spu_en` and `done` are low and both error flags are low until a transaction sets them.
- R2: Each phase opens with one reset slot. If the response bit `rsp_bit` is 0 (no presence), the block goes back to idle and issues no further slot. In the cycle after that response it pulses `done` with `err_nodev` = 1.
- R3: After a successful presence response, the block sends the select code 55h and then the 64 identifier bits, one write slot per bit. Every byte goes least significant bit first, and the identifier is sent from `dev_id[0]` up to `dev_id[63]`.
- R4: In the first phase the identifier is followed by the 8 bits of command 44h, least significant bit first.
- R5: `spu_en` rises in the cycle right after the completion of the last write slot of the 44h command. It stays high for exactly `HOLD_CYCLES` clock cycles, and no slot is requested while it is high.
- R6: After the hold, the second phase repeats the reset slot, the presence check, 55h and the identifier. It then sends command BEh, least significant bit first.
- R7: The second phase then issues 72 read slots. The first bit received lands in `scratch[0]` and the last in `scratch[71]`.
- R8: The 72 received bits are run serially, least significant bit first, through the CRC with polynomial x^8+x^5+x^4+1 (initial value 0). When `done` pulses, `err_crc` is 1 exactly when the remainder is nonzero.
- R9: `done` is a one-cycle pulse. A `start` that arrives while a transaction is running is ignored and produces no extra `done`.
- R10: Slot requests use the encoding `req_kind` = 0 for reset/presence, 1 for write (the bit to send is on `req_wbit`) and 2 for read. A new request is made only after the previous one has reported `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (one-cycle pulse) |
| dev_id | input | 64 | Identifier of the device to address, latched on start |
| req_go | output | 1 | One-cycle request for a slot |
| req_kind | output | 2 | Slot kind: 0 reset, 1 write, 2 read |
| req_wbit | output | 1 | Bit to send for a write slot |
| rsp_done | input | 1 | Slot engine completion pulse |
| rsp_bit | input | 1 | Presence result (1 = present) or bit read |
| spu_en | output | 1 | Strong pull-up enable for the pad |
| scratch | output | 72 | Received scratchpad, first bit in bit 0 |
| done | output | 1 | Transaction finished pulse |
| err_nodev | output | 1 | No presence response seen |
| err_crc | output | 1 | Scratchpad CRC remainder nonzero |

## Verification
The hardest case to reach from the ports is a presence failure in the second phase. By then the first phase has already run to completion, including the full strong pull-up hold. The bench slot-engine model takes a separate presence answer for each reset slot it serves, so the stimulus can succeed on the first reset and fail on the second. The bench then checks that exactly 80 write bits and one full hold happened before the abort. A corrupted CRC byte is built the same way: the bench computes the valid check byte and flips one bit of it before serving the reads.

// File: rtl/ss_pkg.sv
// Shared types for the sensor sequencer.
// Assumes: slot-kind codes are shared with the external bit-slot engine.
package ss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_SEND,
        ST_HOLD,
        ST_RECV,
        ST_FIN
    } seq_state_t;

    localparam logic [1:0] KIND_RESET = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_READ  = 2'd2;

    localparam logic [7:0] CMD_SELECT  = 8'h55;
    localparam logic [7:0] CMD_CONVERT = 8'h44;
    localparam logic [7:0] CMD_READSP  = 8'hBE;
endpackage

// File: rtl/ss_crc8.sv
// Serial CRC-8 (x^8+x^5+x^4+1), fed least significant bit first.
// Assumes: clr and en are never high in the same cycle.
module ss_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);
    logic       fb;
    logic [7:0] nxt;

    // Reflected feedback step for one incoming bit.
    always_comb begin
        fb  = crc[0] ^ din;
        nxt = {1'b0, crc[7:1]} ^ (fb ? 8'h8C : 8'h00);
    end

    // Remainder register: cleared per transaction, advanced per bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '0;
        else if (en)       crc <= nxt;
    end

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 8'h00));
endmodule

// File: rtl/ss_hold_timer.sv
// Counts the strong pull-up hold window.
// Assumes: run stays high until expire is seen; LIMIT >= 1.
module ss_hold_timer #(
    parameter int LIMIT = 750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(LIMIT - 1));

    // Cycle counter, parked at zero while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expire)   cnt <= cnt + 1'b1;
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/sensor_seq.sv
// Two-phase addressed sensor transaction sequencer.
// Phase 0: reset, select+ID, convert, strong pull-up hold.
// Phase 1: reset, select+ID, read command, 72 read slots, CRC check.
// Assumes: the slot engine answers every req_go with exactly one rsp_done.
module sensor_seq #(
    parameter int HOLD_CYCLES = 750000,
    parameter int ID_W        = 64,
    parameter int SP_BYTES    = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ID_W-1:0]       dev_id,
    output logic                  req_go,
    output logic [1:0]            req_kind,
    output logic                  req_wbit,
    input  logic                  rsp_done,
    input  logic                  rsp_bit,
    output logic                  spu_en,
    output logic [SP_BYTES*8-1:0] scratch,
    output logic                  done,
    output logic                  err_nodev,
    output logic                  err_crc
);
    import ss_pkg::*;

    localparam int TX_BITS = ID_W + 16;
    localparam int RX_BITS = SP_BYTES * 8;
    localparam int MAXB    = (TX_BITS > RX_BITS) ? TX_BITS : RX_BITS;
    localparam int BW      = $clog2(MAXB + 1);

    seq_state_t          state;
    logic                phase;
    logic                pend;
    logic [BW-1:0]       bitcnt;
    logic [TX_BITS-1:0]  txsr;
    logic [ID_W-1:0]     id_q;
    logic [7:0]          crc;
    logic                hold_exp;
    logic                crc_clr, crc_en;

    // Slot request decode from registered state.
    always_comb begin
        req_go   = (state == ST_RST || state == ST_SEND || state == ST_RECV) && !pend;
        req_kind = (state == ST_RST)  ? KIND_RESET :
                   (state == ST_SEND) ? KIND_WRITE : KIND_READ;
        req_wbit = txsr[0];
        spu_en   = (state == ST_HOLD);
        crc_clr  = (state == ST_IDLE) && start;
        crc_en   = (state == ST_RECV) && rsp_done;
    end

    ss_crc8 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (rsp_bit),
        .crc   (crc)
    );

    ss_hold_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (spu_en),
        .expire (hold_exp)
    );

    // Main sequencer: walks phases, shifts bits, flags errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= 1'b0;
            pend      <= 1'b0;
            bitcnt    <= '0;
            txsr      <= '0;
            id_q      <= '0;
            scratch   <= '0;
            done      <= 1'b0;
            err_nodev <= 1'b0;
            err_crc   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (req_go) pend <= 1'b1;
            case (state)
                ST_IDLE: if (start) begin
                    id_q      <= dev_id;
                    phase     <= 1'b0;
                    pend      <= 1'b0;
                    err_nodev <= 1'b0;
                    err_crc   <= 1'b0;
                    state     <= ST_RST;
                end
                ST_RST: if (rsp_done) begin
                    pend <= 1'b0;
                    if (!rsp_bit) begin
                        err_nodev <= 1'b1;
                        done      <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        txsr   <= {phase ? CMD_READSP : CMD_CONVERT, id_q, CMD_SELECT};
                        bitcnt <= '0;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: if (rsp_done) begin
                    pend   <= 1'b0;
                    txsr   <= txsr >> 1;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == BW'(TX_BITS - 1)) begin
                        bitcnt <= '0;
                        state  <= phase ? ST_RECV : ST_HOLD;
                    end
                end
                ST_HOLD: if (hold_exp) begin
                    phase <= 1'b1;
                    state <= ST_RST;
                end
                ST_RECV: if (rsp_done) begin
                    pend    <= 1'b0;
                    scratch <= {rsp_bit, scratch[RX_BITS-1:1]};
                    bitcnt  <= bitcnt + 1'b1;
                    if (bitcnt == BW'(RX_BITS - 1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    err_crc <= (crc != 8'h00);
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!req_go && !spu_en));
    p_abort_nodev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST && rsp_done && !rsp_bit) |=> (done && err_nodev && !req_go));
    p_hold_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spu_en |-> !req_go);
    p_spu_after_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && rsp_done && !phase && bitcnt == BW'(TX_BITS - 1)) |=> spu_en);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_kind_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_go |-> (req_kind != 2'd3));
endmodule

// File: tb/sim_sensor_seq.sv
module sim_sensor_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 40;
    localparam int LAT        = 3;

    typedef struct packed {
        logic [63:0] id;
        logic [63:0] data;
        logic        bad;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{64'h28FF_1234_5678_9ABC, 64'h0123_4567_89AB_CDEF, 1'b0},
        '{64'hA5A5_0000_FFFF_5A5A, 64'h0000_0000_0000_0000, 1'b0},
        '{64'h0102_0304_0506_0708, 64'hDEAD_BEEF_0BAD_F00D, 1'b1},
        '{64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dev_id = '0;
    logic        req_go, req_wbit, rsp_done, rsp_bit, spu_en;
    logic [1:0]  req_kind;
    logic [71:0] scratch;
    logic        done, err_nodev, err_crc;

    int n_chk = 0, n_bad = 0;

    // Slot engine model state and logs
    logic        eng_busy = 1'b0;
    int          eng_cnt = 0;
    logic [1:0]  eng_kind = '0;
    logic        wlog [160];
    int          wcnt = 0, rstcnt = 0, rd_idx = 0;
    int          spu_cyc = 0, hold_viol = 0, done_cnt = 0, cyc = 0;
    int          kind_bad = 0;
    logic [1:0]  pres_cfg = 2'b11;
    logic [71:0] sp_src = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sensor_seq #(.HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_id(dev_id),
        .req_go(req_go), .req_kind(req_kind), .req_wbit(req_wbit),
        .rsp_done(rsp_done), .rsp_bit(rsp_bit), .spu_en(spu_en),
        .scratch(scratch), .done(done), .err_nodev(err_nodev), .err_crc(err_crc)
    );

    // Bit-slot engine model plus monitors.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_bit  <= 1'b0;
            eng_busy = 1'b0;
        end else begin
            rsp_done <= 1'b0;
            if (spu_en) spu_cyc = spu_cyc + 1;
            if (spu_en && req_go) hold_viol = hold_viol + 1;
            if (done) done_cnt = done_cnt + 1;
            if (req_go && eng_busy) kind_bad = kind_bad + 1;
            if (req_go && !eng_busy) begin
                eng_busy = 1'b1;
                eng_cnt  = LAT;
                eng_kind = req_kind;
                if (req_kind == 2'd1 && wcnt < 160) begin
                    wlog[wcnt] = req_wbit;
                    wcnt = wcnt + 1;
                end
                if (req_kind == 2'd0) rstcnt = rstcnt + 1;
                if (req_kind == 2'd3) kind_bad = kind_bad + 1;
            end else if (eng_busy) begin
                eng_cnt = eng_cnt - 1;
                if (eng_cnt == 0) begin
                    eng_busy = 1'b0;
                    rsp_done <= 1'b1;
                    if (eng_kind == 2'd0) rsp_bit <= pres_cfg[(rstcnt - 1) & 1];
                    else if (eng_kind == 2'd2) begin
                        rsp_bit <= sp_src[rd_idx];
                        rd_idx = rd_idx + 1;
                    end else rsp_bit <= 1'b0;
                end
            end
        end
    end

    // Reference CRC-8, x^8+x^5+x^4+1, bits taken LSB first.
    function automatic logic [7:0] ref_crc(input logic [71:0] v, input int nbits);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            logic t = r[0] ^ v[i];
            r = r >> 1;
            if (t) r = r ^ 8'b1000_1100;
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic clear_logs;
        wcnt = 0; rstcnt = 0; rd_idx = 0; spu_cyc = 0; hold_viol = 0;
        done_cnt = 0; kind_bad = 0;
    endtask

    // Start a transaction; optionally pulse start again mid-run.
    task automatic run_txn(input logic [63:0] id, input logic dup_start);
        int w;
        int target;
        target = done_cnt + 1;
        @(negedge clk);
        dev_id = id;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        dev_id = ~id;
        if (dup_start) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (done_cnt < target && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 20000) chk(1'b0, "R9", "watchdog waiting for done", 0, 1);
        repeat (2000) begin
            @(negedge clk);
            if (eng_busy) continue;
        end
    endtask

    function automatic int wmis(input logic [79:0] e, input int base);
        int m = 0;
        for (int i = 0; i < 80; i++) if (wlog[base + i] !== e[i]) m++;
        return m;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "R9", "global watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset/idle state
        chk(!req_go && !spu_en && !done, "R1", "outputs quiet in reset", {req_go, spu_en, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!req_go && !spu_en && !done && !err_nodev && !err_crc, "R1", "idle after reset",
            {req_go, spu_en, done, err_nodev, err_crc}, 0);

        // Vector table walk
        for (int k = 0; k < 4; k++) begin
            logic [7:0]  c;
            logic [79:0] e0, e1;
            c = ref_crc({8'h00, VEC[k].data}, 64) ^ (VEC[k].bad ? 8'h10 : 8'h00);
            sp_src   = {c, VEC[k].data};
            pres_cfg = 2'b11;
            clear_logs();
            run_txn(VEC[k].id, 1'b0);
            e0 = {8'h44, VEC[k].id, 8'h55};
            e1 = {8'hBE, VEC[k].id, 8'h55};
            chk(wcnt == 160, "R3", "write slot count", wcnt, 160);
            chk(wmis(e0, 0) == 0, "R4", "phase 0 select/id/convert bits", wmis(e0, 0), 0);
            chk(wmis(e1, 80) == 0, "R6", "phase 1 select/id/read-cmd bits", wmis(e1, 80), 0);
            chk(rstcnt == 2, "R2", "reset slots per transaction", rstcnt, 2);
            chk(spu_cyc == HOLD, "R5", "pull-up hold length", spu_cyc, HOLD);
            chk(hold_viol == 0, "R5", "slots during hold", hold_viol, 0);
            chk(rd_idx == 72, "R7", "read slot count", rd_idx, 72);
            chk(scratch == sp_src, "R7", "scratchpad order", scratch, sp_src);
            chk(err_crc == VEC[k].bad, "R8", "crc flag", err_crc, VEC[k].bad);
            chk(err_nodev == 1'b0, "R2", "no-device flag clear", err_nodev, 0);
            chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
            chk(kind_bad == 0, "R10", "request protocol", kind_bad, 0);
        end

        // R2: no presence on first reset
        pres_cfg = 2'b00;
        clear_logs();
        run_txn(64'h1111_2222_3333_4444, 1'b0);
        chk(err_nodev == 1'b1, "R2", "phase 0 abort flag", err_nodev, 1);
        chk(wcnt == 0 && rstcnt == 1, "R2", "no slots after phase 0 abort", {wcnt[7:0], rstcnt[7:0]}, 16'h0001);
        chk(spu_cyc == 0, "R2", "no hold after abort", spu_cyc, 0);

        // R2: presence in phase 0, none in phase 1
        pres_cfg = 2'b01;
        clear_logs();
        run_txn(64'h5555_6666_7777_8888, 1'b0);
        chk(err_nodev == 1'b1, "R2", "phase 1 abort flag", err_nodev, 1);
        chk(wcnt == 80 && rstcnt == 2, "R2", "slots before phase 1 abort", {wcnt[7:0], rstcnt[7:0]}, 16'h5002);
        chk(spu_cyc == HOLD && rd_idx == 0, "R5", "hold done, no reads", {spu_cyc[7:0], rd_idx[7:0]}, {8'(HOLD), 8'h00});

        // R9: start while busy is ignored
        pres_cfg = 2'b11;
        sp_src   = {ref_crc({8'h00, 64'h0F0F_F0F0_3C3C_C3C3}, 64), 64'h0F0F_F0F0_3C3C_C3C3};
        clear_logs();
        run_txn(64'h9999_AAAA_BBBB_CCCC, 1'b1);
        chk(done_cnt == 1 && rstcnt == 2, "R9", "busy start ignored", {done_cnt[7:0], rstcnt[7:0]}, 16'h0102);
        chk(scratch == sp_src && !err_crc, "R9", "result intact after busy start", scratch, sp_src);
        chk(wmis({8'h44, 64'h9999_AAAA_BBBB_CCCC, 8'h55}, 0) == 0, "R3", "latched id used", 0, 0);

        finish_run();
    end
endmodule